// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block recovers stereo PCM samples from a three-wire serial audio link: a bit clock, a word-select line that marks the channel, and a data line. It runs on the system clock. All three link inputs pass through synchronisers, and the rising edges of the bit clock are found by oversampling. A single shift engine then frames each word according to the selected format: I2S (MSB one bit after the word-select change), MSB-justified (MSB on the first bit after the change), or LSB-justified with 16, 18 or 20 bits (LSB on the last bit before the next change).

The format comes from one of two sources. One is a 3-bit code from the control registers. The other is a 2-bit static pin code, which offers only I2S and the three LSB-justified lengths. Each completed stereo pair appears as a signed 20-bit left sample and a signed 20-bit right sample, together with a single-cycle strobe. The system clock must be at least eight times the bit clock.

Top module: `aud_ser_rx`

## Requirements
- R1: While rst_ni is low and after its release, left_o and right_o read 0 and valid_o reads 0 until the first completed frame.
- R2: Data and word select are sampled on each rising bit-clock edge. A word boundary is the first rising edge at which the sampled word-select level differs from its level at the previous rising edge.
- R3: In I2S framing the bit at the boundary is ignored, the next bit is the MSB, and word select low marks the left channel.
- R4: In MSB-justified framing the bit at the boundary is the MSB, and word select high marks the left channel.
- R5: In I2S and MSB-justified framing, bits after the 20th word bit are dropped, and shorter words are zero-padded at the LSB end.
- R6: In LSB-justified framing of N bits (16, 18 or 20), the N bits just before the next boundary form the word, with the last of them as the LSB. The word is sign-extended to 20 bits, earlier bits of the half-frame are ignored, and word select high marks the left channel.
- R7: When fmt_src_i is 0, fmt_reg_i selects the format: 0 = I2S, 1 = LSB-justified 16, 2 = LSB-justified 18, 3 = LSB-justified 20, 4 = MSB-justified. Codes 5 to 7 act as I2S.
- R8: When fmt_src_i is 1, fmt_pin_i selects the format and fmt_reg_i has no effect: 0 = I2S, 1 = LSB-justified 16, 2 = LSB-justified 18, 3 = LSB-justified 20.
- R9: valid_o pulses for exactly one cycle when a right word completes after a left word of the same frame. left_o and right_o change only in that cycle and hold otherwise.
- R10: The format is latched at each word boundary. Bits received before the first boundary after reset never produce a strobe, and exactly one strobe is produced per complete left/right pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial bit clock (asynchronous) |
| ws_i | input | 1 | Word select (asynchronous) |
| sd_i | input | 1 | Serial data (asynchronous) |
| fmt_src_i | input | 1 | 0: register code, 1: pin code |
| fmt_reg_i | input | 3 | Register format code |
| fmt_pin_i | input | 2 | Static pin format code |
| left_o | output | 20 | Left sample, signed |
| right_o | output | 20 | Right sample, signed |
| valid_o | output | 1 | One-cycle strobe per stereo pair |

## Verification
The assertions check on every cycle the properties that hold at all times:
- the strobe lasts a single cycle and is caused by a detected bit-clock edge;
- detected bit edges are never back to back;
- the samples hold between strobes;
- the pin path can never select MSB-justified framing.

Some behaviour only the bench scenarios can show:
- the bit alignment of each format;
- truncation beyond 20 bits and zero padding of short MSB-first words;
- sign extension of LSB-justified words, and that noise ahead of them is ignored;
- the mapping of the register and pin codes;
- that the half-frame before the first boundary is discarded.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_LSB16 = 3'd1,
    FMT_LSB18 = 3'd2,
    FMT_LSB20 = 3'd3,
    FMT_MSBJ  = 3'd4
  } fmt_e;
endpackage

// File: rtl/aud_rx_front.sv
module aud_rx_front #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic bit_stb_o,
  output logic bit_o,
  output logic ws_o
);
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0] raw, synced;
  logic            sck_q;

  assign raw = {sck_i, ws_i, sd_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '0;
      else         chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= synced[2];
  end

  assign bit_stb_o = synced[2] & ~sck_q;
  assign ws_o      = synced[1];
  assign bit_o     = synced[0];
endmodule

// File: rtl/aud_rx_fmt_dec.sv
module aud_rx_fmt_dec
  import aud_rx_pkg::*;
(
  input  logic       src_i,
  input  logic [2:0] reg_code_i,
  input  logic [1:0] pin_code_i,
  output fmt_e       fmt_o
);
  always_comb begin
    if (src_i) begin
      unique case (pin_code_i)
        2'd0: fmt_o = FMT_I2S;
        2'd1: fmt_o = FMT_LSB16;
        2'd2: fmt_o = FMT_LSB18;
        default: fmt_o = FMT_LSB20;
      endcase
    end else begin
      case (reg_code_i)
        3'd1: fmt_o = FMT_LSB16;
        3'd2: fmt_o = FMT_LSB18;
        3'd3: fmt_o = FMT_LSB20;
        3'd4: fmt_o = FMT_MSBJ;
        default: fmt_o = FMT_I2S;
      endcase
    end
  end
endmodule

// File: rtl/aud_rx_shift.sv
module aud_rx_shift
  import aud_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 20,
  localparam int unsigned CNT_W   = $clog2(SAMPLE_W + 2)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_stb_i,
  input  logic                bit_i,
  input  logic                ws_i,
  input  fmt_e                fmt_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam logic [CNT_W-1:0]    IDX_MAX = CNT_W'(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0]    W_LIM   = CNT_W'(SAMPLE_W);
  localparam logic [SAMPLE_W-1:0] TOP_BIT = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic                started_q, armed_q, ws_prev_q, left_done_q;
  fmt_e                fmt_q;
  logic [CNT_W-1:0]    idx_q;
  logic [SAMPLE_W-1:0] acc_q, tail_q, left_hold_q;

  logic                boundary, word_left, off_bit, msb_fmt, place_en;
  logic [CNT_W-1:0]    off_ext, rel;
  logic [SAMPLE_W-1:0] mask, word_val;

  function automatic logic [SAMPLE_W-1:0] sext(input logic [SAMPLE_W-1:0] v,
                                               input int unsigned n,
                                               input logic s);
    logic [SAMPLE_W-1:0] r;
    for (int i = 0; i < SAMPLE_W; i++) r[i] = (i < n) ? v[i] : s;
    return r;
  endfunction

  assign boundary  = bit_stb_i & started_q & (ws_i != ws_prev_q);
  // channel of the word that just ended
  assign word_left = (fmt_q == FMT_I2S) ? ~ws_prev_q : ws_prev_q;

  assign msb_fmt  = (fmt_q == FMT_I2S) || (fmt_q == FMT_MSBJ);
  assign off_bit  = (fmt_q == FMT_I2S);
  assign off_ext  = {{(CNT_W-1){1'b0}}, off_bit};
  assign rel      = idx_q - off_ext;
  assign place_en = msb_fmt && (idx_q >= off_ext) && (rel < W_LIM);
  assign mask     = TOP_BIT >> rel;

  always_comb begin
    case (fmt_q)
      FMT_LSB16: word_val = sext(tail_q, 16, tail_q[15]);
      FMT_LSB18: word_val = sext(tail_q, 18, tail_q[17]);
      FMT_LSB20: word_val = sext(tail_q, 20, tail_q[19]);
      default:   word_val = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q   <= 1'b0;
      armed_q     <= 1'b0;
      ws_prev_q   <= 1'b0;
      left_done_q <= 1'b0;
      fmt_q       <= FMT_I2S;
      idx_q       <= '0;
      acc_q       <= '0;
      tail_q      <= '0;
      left_hold_q <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bit_stb_i) begin
        started_q <= 1'b1;
        ws_prev_q <= ws_i;
        tail_q    <= {tail_q[SAMPLE_W-2:0], bit_i};
        if (boundary) begin
          armed_q <= 1'b1;
          fmt_q   <= fmt_i;
          idx_q   <= CNT_W'(1);
          acc_q   <= (fmt_i == FMT_MSBJ) ? (bit_i ? TOP_BIT : '0) : '0;
          if (armed_q) begin
            if (word_left) begin
              left_hold_q <= word_val;
              left_done_q <= 1'b1;
            end else if (left_done_q) begin
              left_o      <= left_hold_q;
              right_o     <= word_val;
              valid_o     <= 1'b1;
              left_done_q <= 1'b0;
            end
          end
        end else begin
          if (idx_q != IDX_MAX) idx_q <= idx_q + CNT_W'(1);
          if (place_en) acc_q <= bit_i ? (acc_q | mask) : (acc_q & ~mask);
        end
      end
    end
  end
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 20,  // must be >= 20
  parameter int unsigned SYNC_STAGES = 2    // must be >= 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic                fmt_src_i,
  input  logic [2:0]          fmt_reg_i,
  input  logic [1:0]          fmt_pin_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic bit_stb, bit_val, ws_val;
  fmt_e fmt_sel;

  aud_rx_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .sck_i, .ws_i, .sd_i,
    .bit_stb_o(bit_stb), .bit_o(bit_val), .ws_o(ws_val)
  );

  aud_rx_fmt_dec u_dec (
    .src_i(fmt_src_i), .reg_code_i(fmt_reg_i), .pin_code_i(fmt_pin_i),
    .fmt_o(fmt_sel)
  );

  aud_rx_shift #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk_i, .rst_ni,
    .bit_stb_i(bit_stb), .bit_i(bit_val), .ws_i(ws_val), .fmt_i(fmt_sel),
    .left_o, .right_o, .valid_o
  );
endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk #(
  parameter int unsigned SAMPLE_W = 20
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bit_stb,
  input logic                fmt_src_i,
  input logic [2:0]          fmt_sel,
  input logic                valid_o,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o
);
  assert_strobe_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_hold_left_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(left_o));

  assert_hold_right_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(right_o));

  assert_strobe_follows_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_stb));

  assert_edge_isolated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb |=> !bit_stb);

  assert_pin_no_msbj_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_src_i |-> (fmt_sel != 3'd4));
endmodule

bind aud_ser_rx aud_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_stb(bit_stb), .fmt_src_i(fmt_src_i),
  .fmt_sel(fmt_sel), .valid_o(valid_o), .left_o(left_o), .right_o(right_o)
);

// File: tb/sim_aud_ser_rx.sv
`timescale 1ns/1ps
module sim_aud_ser_rx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sck_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic        fmt_src_i = 1'b0;
  logic [2:0]  fmt_reg_i = 3'd0;
  logic [1:0]  fmt_pin_i = 2'd0;
  logic [19:0] left_o, right_o;
  logic        valid_o;

  int checks = 0, errors = 0;
  int strobes = 0;
  string cur_req = "R3";
  logic [39:0] expq[$];
  logic [19:0] last_left = '0;
  logic        prev_valid = 1'b0;
  logic        done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  aud_ser_rx u0 (.*);

  // kind: 0 I2S, 1/2/3 LSB 16/18/20, 4 MSB-justified
  function automatic int lsb_len(int kind);
    return (kind == 1) ? 16 : (kind == 2) ? 18 : 20;
  endfunction

  function automatic logic [19:0] exp_val(int kind, logic [31:0] w, int txw);
    logic [19:0] r;
    if (kind == 0 || kind == 4) begin
      for (int i = 0; i < 20; i++) begin
        int s = txw - 1 - i;
        r[19-i] = (s >= 0) ? w[s] : 1'b0;
      end
    end else begin
      int n = lsb_len(kind);
      for (int i = 0; i < 20; i++) r[i] = (i < n) ? w[i] : w[n-1];
    end
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic send_bit(input logic w, input logic b);
    ws_i = w; sd_i = b;
    #80 sck_i = 1'b1;
    #80 sck_i = 1'b0;
  endtask

  task automatic send_half(input logic w, input int kind, input int nb, input logic [31:0] word, input int txw);
    for (int k = 0; k < nb; k++) begin
      logic b;
      b = 1'($urandom);
      if (kind == 0) begin
        if (k >= 1) b = (k - 1 < txw) ? word[txw-1-(k-1)] : 1'b0;
      end else if (kind == 4) begin
        b = (k < txw) ? word[txw-1-k] : 1'b0;
      end else begin
        int n = lsb_len(kind);
        if (k >= nb - n) b = word[nb-1-k];
      end
      send_bit(w, b);
    end
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (valid_o && prev_valid) check("R9", "strobe width", 40'd1, 40'd0);
      if (valid_o) begin
        strobes++;
        if (expq.size() == 0) check("R10", "unexpected strobe", 40'd1, 40'd0);
        else begin
          logic [39:0] e;
          e = expq.pop_front();
          check(cur_req, "left", {20'd0, left_o}, {20'd0, e[39:20]});
          check(cur_req, "right", {20'd0, right_o}, {20'd0, e[19:0]});
          last_left = e[39:20];
        end
      end
    end
    prev_valid = valid_o;
  end

  task automatic run_session(input string req, input logic src, input logic [2:0] rcode,
                             input logic [1:0] pcode, input int kind, input int nb,
                             input int txw, input int nframes);
    logic lw;
    int wl;
    lw = (kind == 0) ? 1'b0 : 1'b1;
    wl = (kind == 0 || kind == 4) ? txw : lsb_len(kind);
    rst_ni = 1'b0; sck_i = 1'b0; ws_i = 1'b0; sd_i = 1'b0;
    fmt_src_i = src; fmt_reg_i = rcode; fmt_pin_i = pcode;
    expq.delete(); strobes = 0; cur_req = req;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1", "reset outputs", {left_o ^ right_o, 19'd0, valid_o}, 40'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1", "outputs after release", {left_o | right_o, 19'd0, valid_o}, 40'd0);
    // preamble on the right level: must never yield a strobe (R10)
    send_half(~lw, kind, nb, $urandom, wl);
    for (int f = 0; f < nframes; f++) begin
      logic [31:0] lwv, rwv;
      lwv = $urandom; rwv = $urandom;
      if (f == 0) begin
        lwv = 32'h1 << (wl - 1);         // most negative
        rwv = (32'h1 << (wl - 1)) - 1;   // most positive
      end else if (f == 1) begin
        lwv = 32'hFFFF_FFFF; rwv = 32'h1;
      end
      if (wl < 32) begin
        lwv &= (32'h1 << wl) - 1;
        rwv &= (32'h1 << wl) - 1;
      end
      expq.push_back({exp_val(kind, lwv, wl), exp_val(kind, rwv, wl)});
      send_half(lw, kind, nb, lwv, wl);
      send_half(~lw, kind, nb, rwv, wl);
    end
    // trailing left half closes the last right word; its own word stays unpublished
    send_half(lw, kind, nb, $urandom, wl);
    repeat (10) @(negedge clk_i);
    check("R10", "strobe count", 40'(strobes), 40'(nframes));
    check("R9", "left held after unpaired word", {20'd0, left_o}, {20'd0, last_left});
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R3 I2S, full 20-bit words, register code 0 (R7)
    run_session("R3", 1'b0, 3'd0, 2'd3, 0, 32, 20, 5);
    // R5 I2S, 24-bit words truncated
    run_session("R5", 1'b0, 3'd0, 2'd0, 0, 32, 24, 4);
    // R5 I2S, 16-bit words zero-padded, short half-frames
    run_session("R5", 1'b0, 3'd0, 2'd0, 0, 24, 16, 4);
    // R4 MSB-justified, register code 4 (R7)
    run_session("R4", 1'b0, 3'd4, 2'd0, 4, 32, 24, 4);
    run_session("R4", 1'b0, 3'd4, 2'd0, 4, 24, 18, 4);
    // R6 LSB-justified lengths via register codes 1..3 (R7)
    run_session("R6", 1'b0, 3'd1, 2'd0, 1, 32, 16, 4);
    run_session("R6", 1'b0, 3'd2, 2'd0, 2, 24, 18, 4);
    run_session("R6", 1'b0, 3'd3, 2'd0, 3, 32, 20, 4);
    // R7 unused register code falls back to I2S
    run_session("R7", 1'b0, 3'd6, 2'd2, 0, 32, 20, 3);
    // R8 pin path, register code 4 must have no effect
    run_session("R8", 1'b1, 3'd4, 2'd0, 0, 32, 20, 3);
    run_session("R8", 1'b1, 3'd4, 2'd1, 1, 32, 16, 3);
    run_session("R8", 1'b1, 3'd0, 2'd2, 2, 32, 18, 3);
    run_session("R8", 1'b1, 3'd0, 2'd3, 3, 24, 20, 3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule